// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Branch Condition Test

This block is the arithmetic core of a small processor. It holds one accumulator and a four-bit condition-code register. It applies one operation per strobe to the accumulator and an operand byte. Each operation follows its own rule for which of the accumulator and the four flags it changes. A flag that an operation does not touch keeps its old value. This lets a later branch test a flag that was produced several operations earlier.

The ALU result is always driven on a result bus. A per-operation write enable decides whether the accumulator captures it. Compare uses the same subtract path as subtract, but its write enable is low, so it changes only the flags. A separate condition selector is decoded against the registered flags. It produces a combinational taken or not-taken decision. Fetch, addressing, memory and program-counter arithmetic are handled elsewhere.

Top module: `accu_flag_unit`

## Requirements
- R1: Opcode 0 (add) loads acc+operand modulo 2^W into the accumulator. N is result MSB, Z is set when the result is zero, C is the carry out, and V is set when both inputs share a sign that differs from the result sign.
- R2: Opcode 1 (subtract) loads acc-operand. C is set when operand > acc (unsigned). V is set when the input signs differ and the result sign differs from the acc sign. N and Z follow the result.
- R3: Opcode 2 (compare) sets all four flags exactly as subtract does and leaves the accumulator unchanged.
- R4: `result_bus` always shows the ALU result of the presented opcode, whether or not it is latched. This holds with the strobe low and for compare. Opcode 7 drives the accumulator value.
- R5: Opcode 3 (increment) and opcode 4 (decrement) load acc+1 or acc-1 and update N and Z from the result. V is set only when increment starts from 0x7F or decrement starts from 0x80. C keeps its value.
- R6: Opcode 5 (store) leaves the accumulator unchanged. It sets N and Z from the accumulator, clears V and keeps C.
- R7: Opcode 6 (load) copies the operand into the accumulator. It sets N and Z from the operand, clears V and keeps C.
- R8: With `op_valid` low, or with opcode 7, neither the accumulator nor the flags change.
- R9: `cond_sel` codes give `branch_taken` as follows:
  - 0: always.
  - 1: Z.
  - 2: !Z.
  - 3: C.
  - 4: !C.
  - 5: !C&&!Z (higher).
  - 6: C||Z (lower or same).
  - 7: N.
  - 8: !N.
  - 9: V.
  - 10: !V.
  - 11 to 15: never.
- R10: `branch_taken` is combinational from the currently held flags. A flag set several operations earlier and not touched since decides the branch.
- R11: A synchronous active-high reset clears the accumulator and all four flags. `flags_out` is packed as {N,Z,V,C} in bits 3 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation strobe; state updates on the edge where it is high |
| op_code | input | 3 | Operation selector (0 add … 7 reserved) |
| operand | input | W | Second operand byte |
| cond_sel | input | 4 | Branch condition selector |
| acc_out | output | W | Registered accumulator |
| flags_out | output | 4 | Registered flags {N,Z,V,C} |
| result_bus | output | W | Combinational ALU result |
| branch_taken | output | 1 | Combinational branch decision from held flags |

## Verification
The assertions assume that `op_code`, `operand` and `op_valid` are known and steady around each rising edge. They also assume that reset is held for at least one edge before the first operation. The bench meets this by changing inputs only on falling edges and by holding reset for several cycles at the start. The random stimulus draws every opcode, including the reserved one, and sometimes drops the strobe. It checks all sixteen condition codes after every step, so flags held across increments, stores and idle cycles are tested for branching.

// File: rtl/accu_pkg.sv
package accu_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CMP   = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4,
    OP_STORE = 3'd5,
    OP_LOAD  = 3'd6,
    OP_NONE  = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0,
    CC_EQ     = 4'd1,
    CC_NE     = 4'd2,
    CC_CS     = 4'd3,
    CC_CC     = 4'd4,
    CC_HI     = 4'd5,
    CC_LS     = 4'd6,
    CC_MI     = 4'd7,
    CC_PL     = 4'd8,
    CC_VS     = 4'd9,
    CC_VC     = 4'd10
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/accu_arith.sv
module accu_arith
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  ccr_t         flags_in,
  output logic [W-1:0] result,
  output ccr_t         flags_nxt,
  output logic         acc_we
);
  localparam int M = W - 1;
  localparam logic [W-1:0] ONE     = {{M{1'b0}}, 1'b1};
  localparam logic [W-1:0] POS_MAX = {1'b0, {M{1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {M{1'b0}}};

  logic [W:0] sum_w;
  logic [W:0] diff_w;

  assign sum_w  = {1'b0, acc} + {1'b0, opnd};
  assign diff_w = {1'b0, acc} - {1'b0, opnd};

  always_comb begin
    result    = acc;
    flags_nxt = flags_in;
    acc_we    = 1'b0;
    unique case (op)
      OP_ADD: begin
        result      = sum_w[M:0];
        acc_we      = 1'b1;
        flags_nxt.c = sum_w[W];
        flags_nxt.v = (acc[M] == opnd[M]) && (sum_w[M] != acc[M]);
      end
      OP_SUB, OP_CMP: begin
        result      = diff_w[M:0];
        acc_we      = (op == OP_SUB);
        flags_nxt.c = diff_w[W];
        flags_nxt.v = (acc[M] != opnd[M]) && (diff_w[M] != acc[M]);
      end
      OP_INC: begin
        result      = acc + ONE;
        acc_we      = 1'b1;
        flags_nxt.v = (acc == POS_MAX);
      end
      OP_DEC: begin
        result      = acc - ONE;
        acc_we      = 1'b1;
        flags_nxt.v = (acc == NEG_MIN);
      end
      OP_STORE: begin
        result      = acc;
        flags_nxt.v = 1'b0;
      end
      OP_LOAD: begin
        result      = opnd;
        acc_we      = 1'b1;
        flags_nxt.v = 1'b0;
      end
      default: begin
        result = acc;
      end
    endcase
    if (op != OP_NONE) begin
      flags_nxt.n = result[M];
      flags_nxt.z = (result == '0);
    end
  end
endmodule

// File: rtl/accu_state.sv
module accu_state
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  op_e          op,
  input  logic         acc_we,
  input  logic [W-1:0] result,
  input  ccr_t         flags_nxt,
  output logic [W-1:0] acc_q,
  output ccr_t         flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (strobe) begin
      if (acc_we) acc_q <= result;
      flags_q <= flags_nxt;
    end
  end

  p_cmp_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe && op == OP_CMP) |=> $stable(acc_q));

  p_carry_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe && (op == OP_INC || op == OP_DEC || op == OP_STORE || op == OP_LOAD))
      |=> $stable(flags_q.c));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!strobe || op == OP_NONE) |=> ($stable(acc_q) && $stable(flags_q)));

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && flags_q == '0));
endmodule

// File: rtl/accu_branch.sv
module accu_branch
  import accu_pkg::*;
(
  input  logic [3:0] cond,
  input  ccr_t       flags,
  output logic       taken
);
  always_comb begin
    unique case (cond)
      CC_ALWAYS: taken = 1'b1;
      CC_EQ:     taken = flags.z;
      CC_NE:     taken = !flags.z;
      CC_CS:     taken = flags.c;
      CC_CC:     taken = !flags.c;
      CC_HI:     taken = !(flags.c || flags.z);
      CC_LS:     taken = flags.c || flags.z;
      CC_MI:     taken = flags.n;
      CC_PL:     taken = !flags.n;
      CC_VS:     taken = flags.v;
      CC_VC:     taken = !flags.v;
      default:   taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/accu_flag_unit.sv
module accu_flag_unit
  import accu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] operand,
  input  logic [3:0]   cond_sel,
  output logic [W-1:0] acc_out,
  output logic [3:0]   flags_out,
  output logic [W-1:0] result_bus,
  output logic         branch_taken
);
  op_e          op;
  logic [W-1:0] acc_q;
  ccr_t         flags_q;
  ccr_t         flags_nxt;
  logic         acc_we;

  assign op = op_e'(op_code);

  accu_arith #(.W(W)) u_arith (
    .op       (op),
    .acc      (acc_q),
    .opnd     (operand),
    .flags_in (flags_q),
    .result   (result_bus),
    .flags_nxt(flags_nxt),
    .acc_we   (acc_we)
  );

  accu_state #(.W(W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .strobe   (op_valid),
    .op       (op),
    .acc_we   (acc_we),
    .result   (result_bus),
    .flags_nxt(flags_nxt),
    .acc_q    (acc_q),
    .flags_q  (flags_q)
  );

  accu_branch u_branch (
    .cond (cond_sel),
    .flags(flags_q),
    .taken(branch_taken)
  );

  assign acc_out   = acc_q;
  assign flags_out = flags_q;

  p_zero_tracks_bus_r1: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == OP_ADD || op == OP_SUB || op == OP_CMP))
      |=> (flags_out[2] == ($past(result_bus) == '0)));

  p_sub_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_SUB) |=> (acc_out == $past(result_bus)));
endmodule

// File: tb/accu_flag_unit_tb.sv
module accu_flag_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [2:0] op_code;
  logic [7:0] operand;
  logic [3:0] cond_sel;
  logic [7:0] acc_out;
  logic [3:0] flags_out;
  logic [7:0] result_bus;
  logic       branch_taken;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_acc;
  logic [3:0] m_flg;

  always #(CLK_PERIOD/2) clk = ~clk;

  accu_flag_unit #(.W(8)) u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .cond_sel(cond_sel), .acc_out(acc_out),
    .flags_out(flags_out), .result_bus(result_bus), .branch_taken(branch_taken)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1 add";
      3'd1: return "R2 sub";
      3'd2: return "R3 cmp";
      3'd3: return "R5 inc";
      3'd4: return "R5 dec";
      3'd5: return "R6 store";
      3'd6: return "R7 load";
      default: return "R8 reserved";
    endcase
  endfunction

  task automatic model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] f, output logic [7:0] res,
                       output logic [7:0] na, output logic [3:0] nf);
    logic [8:0] wide;
    logic c, v;
    c = f[0]; v = f[1]; res = a; na = a; nf = f;
    case (op)
      3'd0: begin
        wide = a + b; res = wide[7:0]; c = wide[8];
        v = (a[7] == b[7]) && (res[7] != a[7]); na = res;
      end
      3'd1, 3'd2: begin
        res = a - b; c = (b > a);
        v = (a[7] != b[7]) && (res[7] != a[7]);
        na = (op == 3'd1) ? res : a;
      end
      3'd3: begin res = a + 8'd1; v = (a == 8'h7f); na = res; end
      3'd4: begin res = a - 8'd1; v = (a == 8'h80); na = res; end
      3'd5: begin res = a; v = 1'b0; end
      3'd6: begin res = b; v = 1'b0; na = b; end
      default: ;
    endcase
    if (op != 3'd7) nf = {res[7], res == 8'd0, v, c};
  endtask

  function automatic logic exp_br(input logic [3:0] cs, input logic [3:0] f);
    logic n, z, v, c;
    {n, z, v, c} = f;
    case (cs)
      4'd0: return 1'b1;
      4'd1: return z;
      4'd2: return !z;
      4'd3: return c;
      4'd4: return !c;
      4'd5: return !c && !z;
      4'd6: return c || z;
      4'd7: return n;
      4'd8: return !n;
      4'd9: return v;
      4'd10: return !v;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " acc"}, acc_out, m_acc);
    chk({tag, " flags"}, flags_out, m_flg);
    for (int k = 0; k < 16; k++) begin
      cond_sel = k[3:0];
      #1;
      chk($sformatf("R9 R10 cond=%0d", k), branch_taken, exp_br(k[3:0], m_flg));
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] b, input logic v);
    logic [7:0] res, na;
    logic [3:0] nf;
    @(negedge clk);
    op_valid = v; op_code = op; operand = b;
    model(op, m_acc, b, m_flg, res, na, nf);
    #1;
    chk("R4 bus", result_bus, res);
    @(negedge clk);
    op_valid = 1'b0;
    if (v) begin m_acc = na; m_flg = nf; end
    check_state(v ? tag_of(op) : "R8 idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_valid = 1'b0; op_code = '0; operand = '0; cond_sel = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = 8'd0; m_flg = 4'd0;
    check_state("R11 reset");

    do_op(3'd6, 8'h7f, 1'b1);   // R7 load
    do_op(3'd0, 8'h01, 1'b1);   // R1 0x7F+1: N,V set
    do_op(3'd0, 8'h80, 1'b1);   // R1 0x80+0x80: zero with carry
    do_op(3'd4, 8'h00, 1'b1);   // R5 dec keeps carry
    do_op(3'd5, 8'h00, 1'b1);   // R6 store keeps carry
    do_op(3'd6, 8'h00, 1'b1);   // R7 load zero, carry still held for R10
    do_op(3'd1, 8'h01, 1'b1);   // R2 0-1 borrow
    do_op(3'd2, 8'hff, 1'b1);   // R3 equal compare, acc stays
    do_op(3'd2, 8'h10, 1'b0);   // R8 strobe low, R4 bus still live
    do_op(3'd7, 8'h55, 1'b1);   // R8 reserved opcode
    do_op(3'd3, 8'h00, 1'b1);   // R5 0xFF+1 wraps to zero
    do_op(3'd6, 8'h80, 1'b1);
    do_op(3'd4, 8'h00, 1'b1);   // R5 dec from 0x80 sets V

    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [7:0] b;
      logic v;
      op = 3'($urandom_range(0, 7));
      b  = 8'($urandom_range(0, 255));
      if (i % 5 == 0) b = ($urandom_range(0, 1) != 0) ? m_acc : 8'h80;
      v  = ($urandom_range(0, 7) != 0);
      do_op(op, b, v);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule